// File: doc/BRIEF.md
# Landing-Pad Enable Configuration Registers

This block holds the per-privilege enables for forward-edge landing-pad checking. Three enable flops live behind a CSR-style port. The first is a machine-only enable in the machine security configuration register. The other two are the landing-pad enable bits in the machine and supervisor environment configuration registers. The core presents an address, write data and a write strobe together with its current privilege. A write is legalized on the clock edge, and the register content can be read back combinationally on the same port.

From the stored enables, the current privilege and a strap that says whether supervisor mode exists, the block drives one output that says whether landing pads are enforced at the current privilege. A parameter removes the extension. When it is removed, every enable reads as zero and the output stays low. Only the enable bits are stored. Every other field of the three registers reads as zero.

Top module: `lpe_csr_top`

## Requirements
- R1: After reset, all three enables are zero: every decoded address reads zero and `lp_enabled` is low at every privilege.
- R2: A legal write to address 0x747 stores write-data bit 10 as the machine enable, and a later read of 0x747 returns it in bit 10.
- R3: A legal write to address 0x30A stores write-data bit 2 as the machine environment enable, and a read of 0x30A returns it in bit 2.
- R4: A legal write to address 0x10A stores write-data bit 2 as the supervisor environment enable, and a read of 0x10A returns it in bit 2.
- R5: Every bit other than bit 10 of 0x747 and bit 2 of 0x30A and 0x10A reads as zero, whatever was written. This includes the reserved bits 1 and 3 and bit 0.
- R6: With `LP_IMPL` = 0, writes change nothing and every read returns zero.
- R7: With `XLEN` = 32, address 0x757 decodes as the upper half of the security register. Writes to it are ignored, it reads zero, and the enable at 0x747 keeps its value.
- R8: An access is illegal when the privilege code is below address bits [9:8]. It is also illegal when the privilege code is the reserved value 2, or when it targets 0x10A with supervisor mode absent. An illegal access raises `csr_illegal`, reads zero and does not modify any register. Privilege codes: 0 user, 1 supervisor, 3 machine.
- R9: In machine mode, `lp_enabled` equals the enable at 0x747.
- R10: In supervisor mode, `lp_enabled` equals the enable at 0x30A.
- R11: In user mode, `lp_enabled` equals the enable at 0x10A when supervisor mode exists, and the enable at 0x30A when it does not. Under privilege code 2 it is low.
- R12: With `LP_IMPL` = 0, `lp_enabled` is always low.
- R13: An address outside the decoded set gives `csr_hit` low, `csr_illegal` low, a zero read, and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe |
| priv_lvl | input | 2 | Current privilege code (0 U, 1 S, 3 M) |
| s_mode_present | input | 1 | Strap: supervisor mode implemented |
| csr_rdata | output | XLEN | Legalized read-back value of the addressed register |
| csr_hit | output | 1 | Address decodes to a register of this block |
| csr_illegal | output | 1 | Decoded access from insufficient privilege |
| lp_enabled | output | 1 | Landing pads enforced at the current privilege |

## Verification
The hardest case to reach is the user-mode path without supervisor mode. The enable there is normally written through 0x10A, but with supervisor mode absent that address is illegal. The effective user enable must then follow the 0x30A bit instead. The bench sweeps every privilege and strap value against every address and a set of data patterns. It interleaves illegal writes, so the three enables reach mixed combinations such as the supervisor enable set while the machine environment enable is clear. After every access, each privilege and strap pair is probed, so the selection between the two registers is observed with distinct values.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    localparam logic [11:0] ADDR_SECCFG    = 12'h747;
    localparam logic [11:0] ADDR_SECCFG_HI = 12'h757;
    localparam logic [11:0] ADDR_MENV      = 12'h30A;
    localparam logic [11:0] ADDR_SENV      = 12'h10A;

    localparam int MLPE_BIT = 10;
    localparam int LPE_BIT  = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SEC,
        SEL_SEC_HI,
        SEL_MENV,
        SEL_SENV
    } csr_sel_e;

    typedef struct packed {
        logic mlpe;
        logic menv_lpe;
        logic senv_lpe;
    } lpe_cfg_t;

endpackage

// File: rtl/lpe_csr_decode.sv
module lpe_csr_decode
    import lpe_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [11:0] addr_i,
    input  priv_e       priv_i,
    input  logic        s_present_i,
    output csr_sel_e    sel_o,
    output logic        hit_o,
    output logic        legal_o
);
    localparam bit HAS_HI = (XLEN == 32);

    logic [1:0] min_priv;

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == ADDR_SECCFG)                 sel_o = SEL_SEC;
        else if (HAS_HI && addr_i == ADDR_SECCFG_HI) sel_o = SEL_SEC_HI;
        else if (addr_i == ADDR_MENV)              sel_o = SEL_MENV;
        else if (addr_i == ADDR_SENV)              sel_o = SEL_SENV;
    end

    assign min_priv = addr_i[9:8];
    assign hit_o    = (sel_o != SEL_NONE);

    always_comb begin
        legal_o = hit_o;
        if (priv_i == PRIV_RSVD)                 legal_o = 1'b0;
        if (2'(priv_i) < min_priv)               legal_o = 1'b0;
        if (sel_o == SEL_SENV && !s_present_i)   legal_o = 1'b0;
    end

endmodule

// File: rtl/lpe_cfg_regs.sv
module lpe_cfg_regs
    import lpe_pkg::*;
#(
    parameter bit LP_IMPL = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we_i,
    input  logic     legal_i,
    input  csr_sel_e sel_i,
    input  logic     wbit_mlpe_i,
    input  logic     wbit_lpe_i,
    output lpe_cfg_t cfg_q
);
    lpe_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (LP_IMPL && we_i && legal_i) begin
            case (sel_i)
                SEL_SEC:  cfg_d.mlpe     = wbit_mlpe_i;
                SEL_MENV: cfg_d.menv_lpe = wbit_lpe_i;
                SEL_SENV: cfg_d.senv_lpe = wbit_lpe_i;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // R8: a rejected access leaves all enables untouched
    a_r8_illegal_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !legal_i) |=> $stable(cfg_q));

    // R7: upper-half write is ignored
    a_r7_hi_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_SEC_HI) |=> $stable(cfg_q));

    // R13: undecoded addresses do not touch state
    a_r13_miss_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_NONE) |=> $stable(cfg_q));

    generate
        if (LP_IMPL) begin : g_impl
            // R3: a legal write lands in the machine environment enable
            a_r3_menv_write: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && legal_i && sel_i == SEL_MENV) |=> (cfg_q.menv_lpe == $past(wbit_lpe_i)));
        end else begin : g_absent
            // R6: enables stay zero without the extension
            a_r6_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_q == '0);
        end
    endgenerate

endmodule

// File: rtl/lpe_enable_sel.sv
module lpe_enable_sel
    import lpe_pkg::*;
#(
    parameter bit LP_IMPL = 1'b1
) (
    input  lpe_cfg_t cfg_i,
    input  priv_e    priv_i,
    input  logic     s_present_i,
    output logic     lp_en_o
);
    logic chosen;

    always_comb begin
        case (priv_i)
            PRIV_M:  chosen = cfg_i.mlpe;
            PRIV_S:  chosen = cfg_i.menv_lpe;
            PRIV_U:  chosen = s_present_i ? cfg_i.senv_lpe : cfg_i.menv_lpe;
            default: chosen = 1'b0;
        endcase
    end

    generate
        if (LP_IMPL) begin : g_on
            assign lp_en_o = chosen;
        end else begin : g_off
            logic unused_chosen;
            assign unused_chosen = chosen;
            assign lp_en_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/lpe_csr_top.sv
module lpe_csr_top
    import lpe_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter bit LP_IMPL = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    input  logic [1:0]      priv_lvl,
    input  logic            s_mode_present,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit,
    output logic            csr_illegal,
    output logic            lp_enabled
);
    csr_sel_e sel;
    logic     legal;
    lpe_cfg_t cfg_q;
    priv_e    priv;
    logic     unused_wdata;

    assign priv         = priv_e'(priv_lvl);
    assign unused_wdata = ^csr_wdata;

    lpe_csr_decode #(.XLEN(XLEN)) u_decode (
        .addr_i      (csr_addr),
        .priv_i      (priv),
        .s_present_i (s_mode_present),
        .sel_o       (sel),
        .hit_o       (csr_hit),
        .legal_o     (legal)
    );

    lpe_cfg_regs #(.LP_IMPL(LP_IMPL)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (csr_we),
        .legal_i     (legal),
        .sel_i       (sel),
        .wbit_mlpe_i (csr_wdata[MLPE_BIT]),
        .wbit_lpe_i  (csr_wdata[LPE_BIT]),
        .cfg_q       (cfg_q)
    );

    lpe_enable_sel #(.LP_IMPL(LP_IMPL)) u_sel (
        .cfg_i       (cfg_q),
        .priv_i      (priv),
        .s_present_i (s_mode_present),
        .lp_en_o     (lp_enabled)
    );

    assign csr_illegal = csr_hit && !legal;

    always_comb begin
        csr_rdata = '0;
        if (legal) begin
            case (sel)
                SEL_SEC:  csr_rdata[MLPE_BIT] = cfg_q.mlpe;
                SEL_MENV: csr_rdata[LPE_BIT]  = cfg_q.menv_lpe;
                SEL_SENV: csr_rdata[LPE_BIT]  = cfg_q.senv_lpe;
                default:  csr_rdata = '0;
            endcase
        end
    end

    // R9: setting the machine enable from machine mode turns enforcement on
    a_r9_machine_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (LP_IMPL && csr_we && legal && sel == SEL_SEC && csr_wdata[MLPE_BIT] && priv == PRIV_M)
        |=> (priv != PRIV_M || lp_enabled));

    // R8: rejected accesses never expose data
    a_r8_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

endmodule

// File: tb/test_lpe_csr_top.sv
`timescale 1ns/1ps
module test_lpe_csr_top;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_we = 1'b0;
    logic [1:0]      priv_lvl = 2'd3;
    logic            s_mode_present = 1'b1;

    logic [XLEN-1:0] rdata, rdata_a;
    logic            hit, hit_a, illegal, illegal_a, lp_en, lp_en_a;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    bit m_sec = 0, m_menv = 0, m_senv = 0;

    always #2.5 clk = ~clk;

    lpe_csr_top #(.XLEN(XLEN), .LP_IMPL(1'b1)) i_lpe_csr_top (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .priv_lvl(priv_lvl), .s_mode_present(s_mode_present),
        .csr_rdata(rdata), .csr_hit(hit), .csr_illegal(illegal), .lp_enabled(lp_en)
    );

    lpe_csr_top #(.XLEN(XLEN), .LP_IMPL(1'b0)) i_lpe_csr_top_absent (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .priv_lvl(priv_lvl), .s_mode_present(s_mode_present),
        .csr_rdata(rdata_a), .csr_hit(hit_a), .csr_illegal(illegal_a), .lp_enabled(lp_en_a)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (addr=%h priv=%0d s=%0b)",
                     req, act, exp, csr_addr, priv_lvl, s_mode_present);
        end
    endtask

    function automatic logic [11:0] addr_of(int i);
        case (i)
            0: return 12'h747;
            1: return 12'h757;
            2: return 12'h30A;
            3: return 12'h10A;
            default: return 12'h123;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] data_of(int i);
        case (i)
            0: return '1;
            1: return '0;
            2: return XLEN'(32'h0000_0400);
            3: return XLEN'(32'h0000_0004);
            default: return XLEN'(32'hFFFF_FBFB);
        endcase
    endfunction

    function automatic bit exp_hit(logic [11:0] a);
        return (a == 12'h747) || (a == 12'h757) || (a == 12'h30A) || (a == 12'h10A);
    endfunction

    function automatic bit exp_legal(logic [11:0] a, logic [1:0] p, bit s);
        if (!exp_hit(a)) return 0;
        if (p == 2'd2) return 0;
        if (p < a[9:8]) return 0;
        if (a == 12'h10A && !s) return 0;
        return 1;
    endfunction

    function automatic logic [XLEN-1:0] exp_read(logic [11:0] a);
        logic [XLEN-1:0] v = '0;
        case (a)
            12'h747: v[10] = m_sec;
            12'h30A: v[2]  = m_menv;
            12'h10A: v[2]  = m_senv;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic bit exp_en(logic [1:0] p, bit s);
        case (p)
            2'd3: return m_sec;
            2'd1: return m_menv;
            2'd0: return s ? m_senv : m_menv;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(logic [11:0] a);
        case (a)
            12'h747: return "R2";
            12'h757: return "R7";
            12'h30A: return "R3";
            12'h10A: return "R4";
            default: return "R13";
        endcase
    endfunction

    task automatic read_check(logic [11:0] a);
        @(negedge clk);
        csr_we = 0; csr_addr = a; priv_lvl = 2'd3; s_mode_present = 1;
        #1;
        chk(req_of(a), rdata, exp_read(a));
        chk("R5", rdata & ~(XLEN'(32'h0000_0404)), '0);
        chk("R6", rdata_a, '0);
    endtask

    task automatic en_sweep();
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                csr_we = 0; csr_addr = 12'h000; priv_lvl = 2'(p); s_mode_present = s[0];
                #1;
                case (p)
                    3: chk("R9", lp_en, exp_en(2'(p), s[0]));
                    1: chk("R10", lp_en, exp_en(2'(p), s[0]));
                    default: chk("R11", lp_en, exp_en(2'(p), s[0]));
                endcase
                chk("R12", lp_en_a, 0);
            end
        end
    endtask

    task automatic access(logic [11:0] a, logic [XLEN-1:0] d, logic [1:0] p, bit s);
        bit lg;
        @(negedge clk);
        csr_addr = a; csr_wdata = d; priv_lvl = p; s_mode_present = s; csr_we = 1;
        lg = exp_legal(a, p, s);
        #1;
        chk("R13", hit, exp_hit(a));
        chk("R8", illegal, exp_hit(a) && !lg);
        chk("R8", illegal_a, exp_hit(a) && !lg);
        if (!lg) chk("R8", rdata, '0);
        @(posedge clk);
        if (lg) begin
            case (a)
                12'h747: m_sec  = d[10];
                12'h30A: m_menv = d[2];
                12'h10A: m_senv = d[2];
                default: ;
            endcase
        end
        #1;
        csr_we = 0;
        read_check(a);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            csr_addr = addr_of(i); priv_lvl = 2'd3; s_mode_present = 1;
            #1;
            chk("R1", rdata, '0);
        end
        en_sweep();

        // R7 targeted: machine enable survives upper-half writes
        access(12'h747, XLEN'(32'h400), 2'd3, 1);
        access(12'h757, '1, 2'd3, 1);
        read_check(12'h747);
        chk("R7", rdata, XLEN'(32'h400));

        // R11 targeted: user mode without supervisor follows 0x30A
        access(12'h10A, '1, 2'd3, 1);
        access(12'h30A, '0, 2'd3, 1);
        en_sweep();
        access(12'h10A, '0, 2'd3, 0);
        en_sweep();

        // near-exhaustive sweep
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 2; s++)
                for (int ai = 0; ai < 5; ai++) begin
                    for (int di = 0; di < 5; di++)
                        access(addr_of(ai), data_of(di), 2'(p), s[0]);
                    en_sweep();
                end

        finish_run();
    end
endmodule